// File: doc/BRIEF.md
# LVDS Pixel Serializer

This block turns a stream of parallel pixels into the seven-slot serial words that feed a flat-panel LVDS link. Each pixel carries 8-bit red, green and blue values and three sync signals (horizontal sync, vertical sync, data enable). The block spreads them over three or four data lanes and produces the matching clock lane pattern. The lane outputs are single-ended logic bits, one per lane per slot, meant to drive external differential buffers.

A single system clock runs the block, and a bit-step enable marks each serial slot. The bit-step enable is expected at seven times the pixel rate. Pixels enter over a valid/ready handshake. Ready is high only in the one enabled cycle that closes slot 6. A pixel offered at that moment is taken into a holding register and sent over the next seven slots. If no pixel is offered at that boundary, the previous pixel is sent again. Input changes between boundaries have no effect on the word being sent.

A static mode input selects the bit placement: an 18-bit layout on three lanes, or one of two 24-bit layouts on four lanes. In the MSB-first 24-bit layout, lanes 0 to 2 carry colour bits 7..2. In the LSB-first layout, those lanes carry bits 5..0. A static mirror input reverses the slot order on the data lanes.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: The slot counter advances by one only on cycles where `bit_en` is high. It counts 0 to 6 and then wraps to 0. Slot 0 is the first slot after reset.
- R2: `lane_clk` is 1 in slots 0, 1, 5 and 6, and 0 in slots 2, 3 and 4. Mirroring does not change it.
- R3: In mode 0 (18-bit), and in reserved mode 3, the data lanes carry the following in slots 0..6, using colour bits 7..2. Lane 0: G2,R7,R6,R5,R4,R3,R2. Lane 1: B3,B2,G7,G6,G5,G4,G3. Lane 2: DE,VS,HS,B7,B6,B5,B4. Lane 3 stays 0.
- R4: In mode 1 (24-bit, MSB-first), lanes 0 to 2 use the R3 layout with colour bits 7..2. Lane 3 carries 0,B1,B0,G1,G0,R1,R0 in slots 0..6.
- R5: In mode 2 (24-bit, LSB-first), lanes 0 to 2 use the R3 layout with colour bits 5..0 in place of 7..2. Lane 3 carries 0,B7,B6,G7,G6,R7,R6 in slots 0..6.
- R6: The three control slots on lane 2 carry data enable in slot 0, vertical sync in slot 1 and horizontal sync in slot 2. The lane 3 bit in slot 0 is always 0.
- R7: When `mirror` is 1, every data lane sends in slot n the bit that the unmirrored layout places in slot 6-n.
- R8: `pix_ready` is 1 exactly when `bit_en` is 1 and the slot is 6. A pixel is taken when `pix_valid` and `pix_ready` are both high, and it appears from the next slot 0. If `pix_valid` is low at that boundary, the held pixel is sent again.
- R9: Reset sets the slot to 0. All data lanes then stay 0 until the first pixel has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Advances the serial slot by one |
| map_mode | input | 2 | Layout: 0 18-bit, 1 24-bit MSB-first, 2 24-bit LSB-first, 3 as 0 |
| mirror | input | 1 | Reverses the slot order on the data lanes |
| pix_valid | input | 1 | A pixel is offered |
| pix_ready | output | 1 | The pixel is taken this cycle |
| pix_r | input | 8 | Red |
| pix_g | input | 8 | Green |
| pix_b | input | 8 | Blue |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| lane_data | output | 4 | Serial bit of each data lane in the current slot |
| lane_clk | output | 1 | Clock lane bit in the current slot |

## Verification
Two things can happen in the same cycle: the pixel capture at the slot-6 boundary, and the output switching to slot 0 of the new word. The old word's last bit and the new word's first bit must not mix. The bench sends new random pixel data every cycle and drops `pix_valid` at random. It also leaves gaps in `bit_en`, so the boundary falls both right after and long after a data change. A behavioural model tracks the slot and the held pixel and checks every lane on every cycle. This shows that a word only ever changes at slot 0, and that a missed handshake repeats the previous pixel.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS   = 7;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;

  typedef enum logic [1:0] {
    MAP_N18     = 2'd0,
    MAP_W24_MSB = 2'd1,
    MAP_W24_LSB = 2'd2,
    MAP_RSVD    = 2'd3
  } map_e;

  // bit s of a lane word is the bit sent in slot s
  typedef logic [SLOTS-1:0] lane_word_t;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  // clock lane: high in slots 0,1,5,6
  localparam lane_word_t CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter #(
  parameter int SLOTS  = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [SLOT_W-1:0] slot,
  output logic              at_last
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  assign at_last = (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (step)
      slot <= at_last ? '0 : slot + 1'b1;
  end
endmodule

// File: rtl/lvds_pixel_hold.sv
module lvds_pixel_hold
  import lvds_ser_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   take,
  input  pixel_t pix_in,
  output pixel_t pix_q,
  output logic   loaded
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      loaded <= 1'b0;
    end else if (take) begin
      pix_q  <= pix_in;
      loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
(
  input  map_e                    mode,
  input  pixel_t                  pix,
  output logic [LANES-1:0][SLOTS-1:0] words
);
  logic [5:0] r6, g6, b6;

  always_comb begin
    if (mode == MAP_W24_LSB) begin
      r6 = pix.r[5:0];
      g6 = pix.g[5:0];
      b6 = pix.b[5:0];
    end else begin
      r6 = pix.r[7:2];
      g6 = pix.g[7:2];
      b6 = pix.b[7:2];
    end
  end

  always_comb begin
    words[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
    words[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
    words[2] = {b6[2], b6[3], b6[4], b6[5], pix.hs, pix.vs, pix.de};
    unique case (mode)
      MAP_W24_MSB: words[3] = {pix.r[0], pix.r[1], pix.g[0], pix.g[1],
                               pix.b[0], pix.b[1], 1'b0};
      MAP_W24_LSB: words[3] = {pix.r[6], pix.r[7], pix.g[6], pix.g[7],
                               pix.b[6], pix.b[7], 1'b0};
      default:     words[3] = '0;
    endcase
  end
endmodule

// File: rtl/lvds_slot_mux.sv
module lvds_slot_mux
  import lvds_ser_pkg::*;
(
  input  logic [SLOT_W-1:0]           slot,
  input  logic                        mirror,
  input  logic                        loaded,
  input  logic [LANES-1:0][SLOTS-1:0] words,
  output logic [LANES-1:0]            lane_bits,
  output logic                        clk_bit
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] eff_slot;

  assign eff_slot = mirror ? (TOP - slot) : slot;
  assign clk_bit  = CLK_PATTERN[slot];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l] = loaded & words[l][eff_slot];
  end
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [1:0]       map_mode,
  input  logic             mirror,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [7:0]       pix_r,
  input  logic [7:0]       pix_g,
  input  logic [7:0]       pix_b,
  input  logic             pix_hs,
  input  logic             pix_vs,
  input  logic             pix_de,
  output logic [LANES-1:0] lane_data,
  output logic             lane_clk
);
  logic [SLOT_W-1:0]           slot_q;
  logic                        slot_last;
  logic                        hold_loaded;
  pixel_t                      pix_in, pix_held;
  logic [LANES-1:0][SLOTS-1:0] words;

  assign pix_in    = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};
  assign pix_ready = bit_en & slot_last;

  lvds_slot_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(bit_en), .slot(slot_q), .at_last(slot_last)
  );

  lvds_pixel_hold u_hold (
    .clk(clk), .rst(rst), .take(pix_valid & pix_ready),
    .pix_in(pix_in), .pix_q(pix_held), .loaded(hold_loaded)
  );

  lvds_lane_mapper u_map (
    .mode(map_e'(map_mode)), .pix(pix_held), .words(words)
  );

  lvds_slot_mux u_mux (
    .slot(slot_q), .mirror(mirror), .loaded(hold_loaded), .words(words),
    .lane_bits(lane_data), .clk_bit(lane_clk)
  );
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic [1:0] map_mode,
  input logic       mirror,
  input logic       pix_ready,
  input logic [3:0] lane_data,
  input logic       lane_clk,
  input logic [2:0] slot,
  input logic       loaded
);
  assert_ready_needs_step_R8: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> (bit_en && slot == 3'd6));

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && slot == 3'd6) |=> (slot == 3'd0));

  assert_slot_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(slot));

  assert_clk_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(lane_clk));

  assert_lane3_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (map_mode == 2'd0 || map_mode == 2'd3) |-> !lane_data[3]);

  assert_ctl3_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ((!mirror && slot == 3'd0) || (mirror && slot == 3'd6)) |-> !lane_data[3]);

  assert_dark_before_load_R9: assert property (@(posedge clk) disable iff (rst)
    !loaded |-> (lane_data == 4'd0));
endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .map_mode(map_mode), .mirror(mirror),
  .pix_ready(pix_ready), .lane_data(lane_data), .lane_clk(lane_clk),
  .slot(slot_q), .loaded(hold_loaded)
);

// File: tb/sim_lvds_pixel_serializer.sv
module sim_lvds_pixel_serializer;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       bit_en = 0;
  logic [1:0] map_mode = 0;
  logic       mirror = 0;
  logic       pix_valid = 0;
  logic       pix_ready;
  logic [7:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic       pix_hs = 0, pix_vs = 0, pix_de = 0;
  logic [3:0] lane_data;
  logic       lane_clk;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int         m_slot = 0;
  bit         m_loaded = 0;
  logic [7:0] m_r = 0, m_g = 0, m_b = 0;
  logic       m_hs = 0, m_vs = 0, m_de = 0;

  lvds_pixel_serializer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .map_mode(map_mode), .mirror(mirror),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected bit of a lane in a logical (unmirrored) slot
  function automatic logic exp_bit(input int mode, input int lane, input int s);
    int lo;
    int base;
    lo = (mode == 2) ? 0 : 2;
    case (lane)
      0: return (s == 0) ? m_g[lo] : m_r[lo + 6 - s];
      1: return (s == 0) ? m_b[lo + 1] : (s == 1) ? m_b[lo] : m_g[lo + 7 - s];
      2: begin
        if (s == 0) return m_de;
        if (s == 1) return m_vs;
        if (s == 2) return m_hs;
        return m_b[lo + 8 - s];
      end
      default: begin
        if (mode == 0 || mode == 3 || s == 0) return 1'b0;
        base = (mode == 1) ? 0 : 6;
        if (s <= 2) return m_b[base + ((s == 1) ? 1 : 0)];
        if (s <= 4) return m_g[base + ((s == 3) ? 1 : 0)];
        return m_r[base + ((s == 5) ? 1 : 0)];
      end
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_slot   = 0;
      m_loaded = 0;
    end else if (bit_en) begin
      if (m_slot == 6 && pix_valid) begin
        m_r = pix_r; m_g = pix_g; m_b = pix_b;
        m_hs = pix_hs; m_vs = pix_vs; m_de = pix_de;
        m_loaded = 1;
      end
      m_slot = (m_slot + 1) % 7;
    end
  end

  // compare every cycle, away from the active edge and after input drive
  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      automatic logic exp_clk = (m_slot <= 1 || m_slot >= 5);
      automatic logic exp_rdy = bit_en && m_slot == 6 && !rst;
      check(lane_clk == exp_clk, "R2", lane_clk, exp_clk);
      check(pix_ready == exp_rdy, "R8", pix_ready, exp_rdy);
      for (int l = 0; l < 4; l++) begin
        automatic int s = mirror ? 6 - m_slot : m_slot;
        automatic logic e = m_loaded ? exp_bit(map_mode, l, s) : 1'b0;
        automatic string tag;
        if (!m_loaded) tag = "R9";
        else if (mirror) tag = "R7";
        else if (l == 2 && s <= 2) tag = "R6";
        else if (map_mode == 1) tag = "R4";
        else if (map_mode == 2) tag = "R5";
        else tag = "R3";
        check(lane_data[l] == e, tag, lane_data[l], e);
      end
    end
  end

  task automatic run_phase(input int mode, input bit mir, input int cycles, input int en_pct);
    map_mode = mode[1:0];
    mirror   = mir;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      bit_en    = ($urandom_range(99) < en_pct);
      pix_valid = ($urandom_range(99) < 80);
      pix_r = $urandom; pix_g = $urandom; pix_b = $urandom;
      {pix_hs, pix_vs, pix_de} = 3'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, slot 0 so clock lane high and lanes dark
    check(lane_data == 4'd0, "R9", lane_data, 0);
    check(lane_clk == 1'b1, "R1", lane_clk, 1);
    rst = 0;
    // R9: lanes dark while bit_en runs but no pixel is offered
    pix_valid = 0;
    bit_en = 1;
    repeat (20) @(negedge clk);
    check(lane_data == 4'd0, "R9", lane_data, 0);
    run_phase(0, 0, 400, 100);
    run_phase(1, 0, 400, 100);
    run_phase(2, 0, 400, 100);
    run_phase(3, 0, 200, 70);
    run_phase(0, 1, 300, 60);
    run_phase(1, 1, 400, 75);
    run_phase(2, 1, 400, 100);
    run_phase(1, 0, 400, 40);
    run_phase(2, 0, 400, 55);
    // R9: reset in mid-stream returns to dark lanes at slot 0
    @(negedge clk);
    rst = 1; bit_en = 1;
    @(negedge clk);
    rst = 0; pix_valid = 0;
    repeat (10) @(negedge clk);
    check(lane_data == 4'd0, "R9", lane_data, 0);
    run_phase(1, 0, 200, 100);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule